// File: doc/BRIEF.md
# Indirect Command Bridge

The bridge lets a host that only performs full 64-bit register accesses reach a 32-bit internal request/response bus. The host sees four registers selected by address bits [4:3]. Writing the control register launches exactly one internal read or write, whose direction, byte count and 32-bit target address are all packed into that single command word. When the internal transfer finishes, a result word carrying a done flag (and, for reads, the returned data) is posted to a status register. Reading the status register returns the result and clears it.

The engine is a three-state machine. `ST_IDLE` waits for a command. `IDLE->ISSUE` is taken on an accepted command (control write, byte count of 8 or less). `ST_ISSUE` drives the one-cycle request, and `ISSUE->WAIT` always follows it. `ST_WAIT` waits for the acknowledge. `WAIT->IDLE` is taken either on the acknowledge or when the wait counter runs out, and the result is posted on that same edge. A command that arrives in `ST_ISSUE` or `ST_WAIT` is dropped. In `ST_IDLE` an acknowledge has no effect.

Bits are given below with bit 0 as the least significant bit of the 64-bit word. Write data travels on `bus_wdata` with the first byte in [31:24], and read data is returned on `bus_rdata` in the same order.

Top module: `icb_bridge`

## Requirements
- R1: `host_addr` selects the register: 0 control, 1 reset, 2 status, 3 data. `host_rdata` reads as zero for control and reset, and as {data register, 32'h0} for data.
- R2: A host write to the data register stores `host_wdata[63:32]`. Host writes to the reset and status registers change nothing that can later be read.
- R3: A control write accepted in `ST_IDLE` raises `bus_req` for exactly one cycle, in the cycle after the write. The command fields are: read flag at bit 48 (1 = read, giving `bus_we` = 0), byte count at [59:56] driven on `bus_size`, and address at [31:0] driven on `bus_addr`.
- R4: A command whose byte count is greater than 8 issues no request and leaves the status register unchanged.
- R5: A write transfer sends the data register value, as it stood when the command was accepted, on `bus_wdata`. On completion the status becomes exactly 64'h800 (done flag at bit 11), whatever `bus_err` says.
- R6: A read acknowledged without error sets the status to 64'h800 OR (`bus_rdata` shifted left by 26), so the data sits in bits [57:26].
- R7: A read acknowledged with `bus_err` = 1 sets the status to 64'h800 OR (32'hFFFFFFFF shifted left by 26).
- R8: Reading the status register returns its current value, and the register holds zero from the next cycle on.
- R9: If no acknowledge arrives within 256 cycles in `ST_WAIT`, the transfer completes as an error: a read posts the all-ones result of R7 and a write posts 64'h800. A later acknowledge has no effect.
- R10: A control write while a transfer is in `ST_ISSUE` or `ST_WAIT` is ignored. It produces no second request and leaves the bus fields unchanged.
- R11: When a completion and a status read fall on the same clock edge, the read returns the older value and the new result is kept in the register.
- R12: After reset, the status and data registers read zero and `bus_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_valid | input | 1 | Host access this cycle |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 2 | Register select (host address bits [4:3]) |
| host_wdata | input | 64 | Host write word |
| host_rdata | output | 64 | Read value of the selected register |
| bus_req | output | 1 | One-cycle request to the internal bus |
| bus_we | output | 1 | 1 = write transfer |
| bus_addr | output | 32 | Internal address |
| bus_size | output | 4 | Byte count |
| bus_wdata | output | 32 | Write bytes, first byte in [31:24] |
| bus_ack | input | 1 | Response strobe |
| bus_err | input | 1 | Error qualifier of `bus_ack` |
| bus_rdata | input | 32 | Read bytes, first byte in [31:24] |

## Verification
Two functions of the block can act on the status register in the same cycle: posting a transfer result and clearing on a host status read. The bench sets up this collision by driving the acknowledge and a status read so that both are sampled on the same edge, while an earlier, unread result is still in the register. Mid-cycle, the read must show that earlier result. The following read must show the new one, and the model run alongside the design checks both on every clock.

// File: rtl/icb_pkg.sv
`timescale 1ns/1ps
package icb_pkg;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_RST  = 2'd1,
        REG_STAT = 2'd2,
        REG_DATA = 2'd3
    } icb_reg_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } icb_state_e;

    localparam int WORD_W     = 64;
    localparam int IBUS_AW    = 32;
    localparam int IBUS_DW    = 32;
    // Field positions, LSB-numbered, of the command and status words
    localparam int RD_FLAG_BIT = 48;
    localparam int SIZE_LSB    = 56;
    localparam int DONE_BIT    = 11;
    localparam int DATA_SHIFT  = 26;

    localparam logic [WORD_W-1:0] DONE_MASK = WORD_W'(1) << DONE_BIT;

    typedef struct packed {
        logic               rd;
        logic [3:0]         size;
        logic [IBUS_AW-1:0] addr;
    } icb_cmd_t;

    function automatic icb_cmd_t unpack_cmd(input logic [WORD_W-1:0] w);
        icb_cmd_t c;
        c.rd   = w[RD_FLAG_BIT];
        c.size = w[SIZE_LSB +: 4];
        c.addr = w[IBUS_AW-1:0];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] pack_result(input logic [IBUS_DW-1:0] d);
        return (WORD_W'(d) << DATA_SHIFT) | DONE_MASK;
    endfunction

endpackage

// File: rtl/icb_timer.sv
`timescale 1ns/1ps
module icb_timer #(
    parameter int LIMIT = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && (cnt == LAST);

    // R9: the wait window never runs past its limit
    p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt == LAST) |=> (!run || cnt == LAST || cnt == '0));

endmodule

// File: rtl/icb_host_regs.sv
`timescale 1ns/1ps
module icb_host_regs
    import icb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_valid,
    input  logic              host_write,
    input  logic [4:3]        host_addr,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [WORD_W-1:0] host_rdata,
    input  logic              post_valid,
    input  logic [WORD_W-1:0] post_value,
    output logic              cmd_go,
    output icb_cmd_t          cmd,
    output logic [IBUS_DW-1:0] data_q
);
    icb_reg_e          sel;
    logic              wr_en;
    logic              rd_en;
    logic [WORD_W-1:0] status_q;

    assign sel    = icb_reg_e'(host_addr);
    assign wr_en  = host_valid && host_write;
    assign rd_en  = host_valid && !host_write;
    assign cmd_go = wr_en && (sel == REG_CTRL);
    assign cmd    = unpack_cmd(host_wdata);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (wr_en && sel == REG_DATA) begin
            data_q <= host_wdata[WORD_W-1 -: IBUS_DW];
        end
    end

    // A posted result takes priority over clear-on-read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
        end else if (post_valid) begin
            status_q <= post_value;
        end else if (rd_en && sel == REG_STAT) begin
            status_q <= '0;
        end
    end

    always_comb begin
        host_rdata = '0;
        unique case (sel)
            REG_CTRL: host_rdata = '0;
            REG_RST:  host_rdata = '0;
            REG_STAT: host_rdata = status_q;
            REG_DATA: host_rdata = {data_q, {(WORD_W-IBUS_DW){1'b0}}};
            default:  host_rdata = '0;
        endcase
    end

    // R8: a status read with nothing to post leaves zero behind
    p_clear_on_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == REG_STAT && !post_valid) |=> (status_q == '0));

    // R11: a posted result always lands, even under a same-edge read
    p_post_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        post_valid |=> (status_q == $past(post_value)));

    // R2: only a data-register write moves the data register
    p_data_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && sel == REG_DATA) |=> $stable(data_q));

endmodule

// File: rtl/icb_cmd_engine.sv
`timescale 1ns/1ps
module icb_cmd_engine
    import icb_pkg::*;
#(
    parameter int MAX_BYTES = 8,
    parameter int TIMEOUT   = 256
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_go,
    input  icb_cmd_t           cmd,
    input  logic [IBUS_DW-1:0] data_q,
    output logic               bus_req,
    output logic               bus_we,
    output logic [IBUS_AW-1:0] bus_addr,
    output logic [3:0]         bus_size,
    output logic [IBUS_DW-1:0] bus_wdata,
    input  logic               bus_ack,
    input  logic               bus_err,
    input  logic [IBUS_DW-1:0] bus_rdata,
    output logic               post_valid,
    output logic [WORD_W-1:0]  post_value
);
    localparam logic [3:0] MAX_SZ = 4'(MAX_BYTES);

    icb_state_e         state_q;
    icb_state_e         state_d;
    logic               size_ok;
    logic               accept;
    logic               waiting;
    logic               expired;
    logic               finish;
    logic               rd_fail;
    logic               op_rd;
    logic [3:0]         op_size;
    logic [IBUS_AW-1:0] op_addr;
    logic [IBUS_DW-1:0] op_wdata;

    assign size_ok = (cmd.size <= MAX_SZ);
    assign accept  = cmd_go && size_ok && (state_q == ST_IDLE);
    assign waiting = (state_q == ST_WAIT);
    assign finish  = waiting && (bus_ack || expired);
    assign rd_fail = !bus_ack || bus_err;

    icb_timer #(.LIMIT(TIMEOUT)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (waiting),
        .expired (expired)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Operation latch: captured once per accepted command
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_rd    <= 1'b0;
            op_size  <= '0;
            op_addr  <= '0;
            op_wdata <= '0;
        end else if (accept) begin
            op_rd    <= cmd.rd;
            op_size  <= cmd.size;
            op_addr  <= cmd.addr;
            op_wdata <= data_q;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = ST_ISSUE;
            ST_ISSUE: state_d = ST_WAIT;
            ST_WAIT:  if (bus_ack || expired) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        bus_req    = 1'b0;
        bus_we     = !op_rd;
        bus_addr   = op_addr;
        bus_size   = op_size;
        bus_wdata  = op_wdata;
        post_valid = 1'b0;
        post_value = '0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_ISSUE: bus_req = 1'b1;
            ST_WAIT: begin
                if (finish) begin
                    post_valid = 1'b1;
                    if (!op_rd) begin
                        post_value = DONE_MASK;
                    end else if (rd_fail) begin
                        post_value = pack_result({IBUS_DW{1'b1}});
                    end else begin
                        post_value = pack_result(bus_rdata);
                    end
                end
            end
            default: ;
        endcase
    end

    // R3: the request is a single-cycle pulse
    p_req_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |=> !bus_req);

    // R3: an accepted command requests on the very next cycle
    p_req_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> bus_req);

    // R4: an oversized command never reaches the bus
    p_size_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_go && cmd.size > MAX_SZ) |=> !bus_req);

    // R10: bus fields stay put while a transfer is outstanding
    p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        waiting |-> ($stable(bus_addr) && $stable(bus_we) && $stable(bus_size)));

    // R9: running out of wait time ends the transfer
    p_timeout_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && expired) |=> (state_q == ST_IDLE));

    // R5: a finished write posts the bare done flag
    p_write_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (post_valid && bus_we) |-> (post_value == DONE_MASK));

endmodule

// File: rtl/icb_bridge.sv
`timescale 1ns/1ps
module icb_bridge
    import icb_pkg::*;
#(
    parameter int MAX_BYTES = 8,
    parameter int TIMEOUT   = 256
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_valid,
    input  logic        host_write,
    input  logic [4:3]  host_addr,
    input  logic [63:0] host_wdata,
    output logic [63:0] host_rdata,
    output logic        bus_req,
    output logic        bus_we,
    output logic [31:0] bus_addr,
    output logic [3:0]  bus_size,
    output logic [31:0] bus_wdata,
    input  logic        bus_ack,
    input  logic        bus_err,
    input  logic [31:0] bus_rdata
);
    logic               cmd_go;
    icb_cmd_t           cmd;
    logic [IBUS_DW-1:0] data_q;
    logic               post_valid;
    logic [WORD_W-1:0]  post_value;

    icb_host_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_valid (host_valid),
        .host_write (host_write),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .post_valid (post_valid),
        .post_value (post_value),
        .cmd_go     (cmd_go),
        .cmd        (cmd),
        .data_q     (data_q)
    );

    icb_cmd_engine #(
        .MAX_BYTES (MAX_BYTES),
        .TIMEOUT   (TIMEOUT)
    ) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_go     (cmd_go),
        .cmd        (cmd),
        .data_q     (data_q),
        .bus_req    (bus_req),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_size   (bus_size),
        .bus_wdata  (bus_wdata),
        .bus_ack    (bus_ack),
        .bus_err    (bus_err),
        .bus_rdata  (bus_rdata),
        .post_valid (post_valid),
        .post_value (post_value)
    );

endmodule

// File: tb/test_icb_bridge.sv
`timescale 1ns/1ps
module test_icb_bridge;

    localparam logic [63:0] DONE = 64'h800;
    localparam int          WAIT_LIMIT = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_valid = 1'b0;
    logic        host_write = 1'b0;
    logic [4:3]  host_addr = 2'd0;
    logic [63:0] host_wdata = '0;
    logic [63:0] host_rdata;
    logic        bus_req;
    logic        bus_we;
    logic [31:0] bus_addr;
    logic [3:0]  bus_size;
    logic [31:0] bus_wdata;
    logic        bus_ack = 1'b0;
    logic        bus_err = 1'b0;
    logic [31:0] bus_rdata = '0;

    int n_chk = 0;
    int n_fail = 0;
    int n_req = 0;
    int cyc = 0;
    bit chk_en = 1'b0;

    always #2 clk = ~clk;

    icb_bridge i_icb_bridge (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_valid (host_valid),
        .host_write (host_write),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .bus_req    (bus_req),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_size   (bus_size),
        .bus_wdata  (bus_wdata),
        .bus_ack    (bus_ack),
        .bus_err    (bus_err),
        .bus_rdata  (bus_rdata)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] mkcmd(input bit rd, input logic [3:0] sz, input logic [31:0] a);
        return (64'(rd) << 48) | (64'(sz) << 56) | 64'(a);
    endfunction

    function automatic logic [63:0] rd_result(input logic [31:0] d);
        return DONE | (64'(d) << 26);
    endfunction

    // ---------------- behavioural reference model ----------------
    logic [63:0] m_stat;
    logic [31:0] m_data;
    int          m_ph;      // 0 idle, 1 request cycle, 2 waiting
    int          m_cnt;
    bit          m_rd;
    logic [31:0] m_addr;
    logic [3:0]  m_size;
    logic [31:0] m_wd;
    bit          m_post;
    logic [63:0] m_pv;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_stat = '0; m_data = '0; m_ph = 0; m_cnt = 0;
            m_rd = 1'b0; m_addr = '0; m_size = '0; m_wd = '0;
        end else begin
            m_post = 1'b0;
            m_pv   = '0;
            if (m_ph == 2) begin
                if (bus_ack) begin
                    m_post = 1'b1;
                    m_pv = !m_rd ? DONE : (bus_err ? rd_result(32'hFFFF_FFFF) : rd_result(bus_rdata));
                    m_ph = 0;
                end else if (m_cnt == WAIT_LIMIT - 1) begin
                    m_post = 1'b1;
                    m_pv = m_rd ? rd_result(32'hFFFF_FFFF) : DONE;
                    m_ph = 0;
                end else begin
                    m_cnt++;
                end
            end else if (m_ph == 1) begin
                m_ph = 2;
                m_cnt = 0;
            end else if (host_valid && host_write && host_addr == 2'd0 && host_wdata[59:56] <= 4'd8) begin
                m_rd = host_wdata[48];
                m_size = host_wdata[59:56];
                m_addr = host_wdata[31:0];
                m_wd = m_data;
                m_ph = 1;
            end
            if (host_valid && host_write && host_addr == 2'd3) m_data = host_wdata[63:32];
            if (m_post) m_stat = m_pv;
            else if (host_valid && !host_write && host_addr == 2'd2) m_stat = '0;
        end
    end

    always @(negedge clk) begin
        if (rst_n && chk_en) begin
            chk("R3 bus_req", 64'(bus_req), 64'(m_ph == 1));
            if (m_ph == 1) begin
                chk("R3 bus_we", 64'(bus_we), 64'(!m_rd));
                chk("R3 bus_addr", 64'(bus_addr), 64'(m_addr));
                chk("R3 bus_size", 64'(bus_size), 64'(m_size));
                if (!m_rd) chk("R5 bus_wdata", 64'(bus_wdata), 64'(m_wd));
            end
            case (host_addr)
                2'd2:    chk("R8 host_rdata status", host_rdata, m_stat);
                2'd3:    chk("R2 host_rdata data", host_rdata, {m_data, 32'h0});
                default: chk("R1 host_rdata zero", host_rdata, 64'h0);
            endcase
        end
    end

    always @(posedge clk) if (rst_n && bus_req) n_req++;

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL R9 watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic host_wr(input logic [1:0] a, input logic [63:0] d);
        @(posedge clk); #1;
        host_valid = 1'b1; host_write = 1'b1; host_addr = a; host_wdata = d;
        @(posedge clk); #1;
        host_valid = 1'b0; host_write = 1'b0; host_wdata = '0;
    endtask

    task automatic host_rd(input logic [1:0] a, output logic [63:0] v);
        @(posedge clk); #1;
        host_valid = 1'b1; host_write = 1'b0; host_addr = a;
        @(negedge clk);
        v = host_rdata;
        @(posedge clk); #1;
        host_valid = 1'b0;
    endtask

    task automatic ack_pulse(input bit err, input logic [31:0] d);
        @(posedge clk); #1;
        bus_ack = 1'b1; bus_err = err; bus_rdata = d;
        @(posedge clk); #1;
        bus_ack = 1'b0; bus_err = 1'b0; bus_rdata = '0;
    endtask

    task automatic do_cmd(input logic [63:0] c, input int dly, input bit err, input logic [31:0] d);
        host_wr(2'd0, c);
        repeat (dly) @(posedge clk);
        ack_pulse(err, d);
    endtask

    initial begin
        logic [63:0] v;
        int req0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        chk_en = 1'b1;

        // R12 reset state
        @(negedge clk);
        chk("R12 bus_req after reset", 64'(bus_req), 64'h0);
        host_rd(2'd2, v); chk("R12 status after reset", v, 64'h0);
        host_rd(2'd3, v); chk("R12 data after reset", v, 64'h0);

        // R1 / R2 register select and data store
        host_wr(2'd3, 64'hA1B2C3D4_55667788);
        host_rd(2'd3, v); chk("R2 data stores upper half", v, 64'hA1B2C3D4_00000000);
        host_rd(2'd0, v); chk("R1 control reads zero", v, 64'h0);
        host_rd(2'd1, v); chk("R1 reset reads zero", v, 64'h0);

        // R5 write transfer, error reported but ignored
        req0 = n_req;
        do_cmd(mkcmd(1'b0, 4'd4, 32'h0000_1234), 2, 1'b1, 32'h0);
        chk("R3 one request per command", 64'(n_req - req0), 64'd1);
        host_rd(2'd2, v); chk("R5 write posts done only", v, DONE);
        host_rd(2'd2, v); chk("R8 status cleared by read", v, 64'h0);

        // R6 successful read
        do_cmd(mkcmd(1'b1, 4'd4, 32'hDEAD_0000), 0, 1'b0, 32'h1234_5678);
        host_rd(2'd2, v); chk("R6 read result packing", v, rd_result(32'h1234_5678));

        // R7 failed read
        do_cmd(mkcmd(1'b1, 4'd8, 32'h0000_00F0), 4, 1'b1, 32'h0BAD_0BAD);
        host_rd(2'd2, v); chk("R7 failed read all ones", v, rd_result(32'hFFFF_FFFF));

        // R4 oversized command; R2 ignored writes to reset and status
        do_cmd(mkcmd(1'b1, 4'd1, 32'h0000_0010), 1, 1'b0, 32'hCAFE_F00D);
        req0 = n_req;
        host_wr(2'd0, mkcmd(1'b1, 4'd9, 32'h0000_0020));
        host_wr(2'd0, mkcmd(1'b0, 4'd15, 32'h0000_0030));
        repeat (6) @(posedge clk);
        chk("R4 no request for oversized", 64'(n_req - req0), 64'd0);
        host_wr(2'd2, 64'hFFFF_FFFF_FFFF_FFFF);
        host_wr(2'd1, 64'hFFFF_FFFF_FFFF_FFFF);
        host_rd(2'd1, v); chk("R2 reset write ignored", v, 64'h0);
        host_rd(2'd2, v); chk("R4 status kept after drop", v, rd_result(32'hCAFE_F00D));

        // R9 timeout on read, then on write, late ack ignored
        host_wr(2'd0, mkcmd(1'b1, 4'd2, 32'h0000_0040));
        repeat (WAIT_LIMIT + 10) @(posedge clk);
        ack_pulse(1'b0, 32'h1111_2222);
        host_rd(2'd2, v); chk("R9 read timeout posts all ones", v, rd_result(32'hFFFF_FFFF));
        host_wr(2'd0, mkcmd(1'b0, 4'd2, 32'h0000_0044));
        repeat (WAIT_LIMIT + 10) @(posedge clk);
        host_rd(2'd2, v); chk("R9 write timeout posts done", v, DONE);

        // R10 command while busy
        req0 = n_req;
        host_wr(2'd0, mkcmd(1'b1, 4'd4, 32'h0000_0100));
        host_wr(2'd0, mkcmd(1'b0, 4'd4, 32'h0000_0200));
        repeat (3) @(posedge clk);
        ack_pulse(1'b0, 32'h0A0B_0C0D);
        repeat (4) @(posedge clk);
        chk("R10 busy command gave no request", 64'(n_req - req0), 64'd1);
        host_rd(2'd2, v); chk("R10 first command result", v, rd_result(32'h0A0B_0C0D));

        // R11 completion and status read on the same edge
        do_cmd(mkcmd(1'b1, 4'd4, 32'h0000_0300), 0, 1'b0, 32'h5555_AAAA);
        host_wr(2'd0, mkcmd(1'b1, 4'd4, 32'h0000_0304));
        @(posedge clk); #1;
        bus_ack = 1'b1; bus_rdata = 32'h7777_3333;
        host_valid = 1'b1; host_write = 1'b0; host_addr = 2'd2;
        @(negedge clk);
        chk("R11 same-edge read sees older", host_rdata, rd_result(32'h5555_AAAA));
        @(posedge clk); #1;
        bus_ack = 1'b0; bus_rdata = '0; host_valid = 1'b0;
        host_rd(2'd2, v); chk("R11 new result kept", v, rd_result(32'h7777_3333));

        repeat (4) @(posedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule